// File: doc/BRIEF.md
# Synchronous VGA Raster Timer

This block produces the raster position for a 640x480 display from one pixel clock. It keeps a horizontal pixel counter and a vertical line counter, and it derives from them the two sync pulses, a display-enable flag, a frame-start strobe and a half-rate pixel enable. Downstream logic uses the half-rate enable to show each image pixel as a 2x2 block.

Every flip-flop shares one clock, and no counter is ever cleared asynchronously. The end of a line is detected at the last count value, one before the line length. The horizontal counter then loads zero on the next edge, so it never shows the line length itself. The vertical counter uses the same end-of-line decode as a clock enable, so both counters change on the same edge. The sync outputs come straight from flip-flops. They are loaded from the next-count decode, so each one changes on the same edge as the counts it reflects. The timing geometry is set by parameters, and the defaults give the standard 800x525 raster.

Top module: `vga_raster_timer`

## Requirements
- R1: On each clock edge with reset released, `h_count` increments by one. At H_TOTAL-1 (799 by default) it loads 0 on the next edge instead.
- R2: `v_count` holds while `h_count` is not H_TOTAL-1. On the edge that wraps `h_count`, it increments, or loads 0 when it was V_TOTAL-1 (524 by default).
- R3: `frame_start` is high for exactly one cycle, the cycle in which both counts are 0 just after a wrap of both counters. It is low after reset.
- R4: `hsync_n` is low exactly in the cycles where `h_count` is in 656..751 (default geometry), and high in all other cycles.
- R5: `vsync_n` is low exactly in the cycles where `v_count` is in 490..491 (default geometry), and high in all other cycles.
- R6: `disp_en` is high exactly when `h_count` < 640 and `v_count` < 480.
- R7: `pix_en` is 0 after reset and inverts on every clock edge. With the default geometry it is therefore high exactly when `h_count` is odd.
- R8: An edge with `rst_n` low puts both counts at 0, `hsync_n` and `vsync_n` at 1, and `pix_en` and `frame_start` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_count | output | CW (10) | Horizontal pixel position |
| v_count | output | CW (10) | Vertical line position |
| hsync_n | output | 1 | Registered horizontal sync, active low |
| vsync_n | output | 1 | Registered vertical sync, active low |
| disp_en | output | 1 | High inside the visible area |
| pix_en | output | 1 | Half-rate enable for 2x2 pixel blocks |
| frame_start | output | 1 | One-cycle strobe at the first cycle of each frame |

## Verification
The hardest events to reach are the vertical wrap and the vertical sync window. With the default geometry one frame takes 420,000 clocks, which is more than a short run allows. The bench therefore runs a second instance with a shrunken 16x10 raster beside the default one. That instance passes through many frame wraps, sync windows and frame strobes. Random synchronous resets land at arbitrary raster positions, and one directed reset is placed on the exact edge where both counters of the small instance would wrap.

// File: rtl/vga_raster_timer.sv
module vga_raster_timer #(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int CW      = $clog2((H_TOTAL > V_TOTAL) ? H_TOTAL : V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] h_count,
  output logic [CW-1:0] v_count,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          disp_en,
  output logic          pix_en,
  output logic          frame_start
);

  localparam int HS_FIRST = H_ACTIVE + H_FRONT;
  localparam int HS_LAST  = HS_FIRST + H_SYNC - 1;
  localparam int VS_FIRST = V_ACTIVE + V_FRONT;
  localparam int VS_LAST  = VS_FIRST + V_SYNC - 1;

  logic          h_last, v_last;
  logic [CW-1:0] h_next, v_next;

  assign h_last = (h_count == CW'(H_TOTAL - 1));
  assign v_last = (v_count == CW'(V_TOTAL - 1));
  assign h_next = h_last ? '0 : h_count + 1'b1;
  assign v_next = !h_last ? v_count : (v_last ? '0 : v_count + 1'b1);
  assign disp_en = (h_count < CW'(H_ACTIVE)) && (v_count < CW'(V_ACTIVE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_count     <= '0;
      v_count     <= '0;
      hsync_n     <= 1'b1;
      vsync_n     <= 1'b1;
      pix_en      <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      h_count     <= h_next;
      v_count     <= v_next;
      hsync_n     <= !((h_next >= CW'(HS_FIRST)) && (h_next <= CW'(HS_LAST)));
      vsync_n     <= !((v_next >= CW'(VS_FIRST)) && (v_next <= CW'(VS_LAST)));
      pix_en      <= ~pix_en;
      frame_start <= h_last && v_last;
    end
  end

  assert_h_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (h_count != CW'(H_TOTAL - 1)) |=> (h_count == $past(h_count) + 1'b1));

  assert_h_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (h_count == CW'(H_TOTAL - 1)) |=> (h_count == '0));

  assert_v_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_count != CW'(H_TOTAL - 1)) |=> $stable(v_count));

  assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_count == CW'(H_TOTAL - 1) && v_count == CW'(V_TOTAL - 1))
      |=> (v_count == '0 && frame_start));

  assert_frame_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  assert_hsync_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> (h_count == CW'(HS_FIRST)));

  assert_vsync_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> (v_count == CW'(VS_FIRST) && h_count == '0));

  assert_pix_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pix_en != $past(pix_en)));

endmodule

// File: tb/vga_raster_timer_tb_top.sv
module vga_raster_timer_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [9:0] bh, bv;
  logic       bhs, bvs, bde, bpx, bfs;
  logic [3:0] sh, sv;
  logic       shs, svs, sde, spx, sfs;

  vga_raster_timer dut_i (
    .clk(clk), .rst_n(rst_n), .h_count(bh), .v_count(bv), .hsync_n(bhs),
    .vsync_n(bvs), .disp_en(bde), .pix_en(bpx), .frame_start(bfs));

  vga_raster_timer #(
    .H_ACTIVE(8), .H_FRONT(2), .H_SYNC(3), .H_BACK(3),
    .V_ACTIVE(6), .V_FRONT(1), .V_SYNC(2), .V_BACK(1)
  ) small_i (
    .clk(clk), .rst_n(rst_n), .h_count(sh), .v_count(sv), .hsync_n(shs),
    .vsync_n(svs), .disp_en(sde), .pix_en(spx), .frame_start(sfs));

  localparam int HA[2] = '{640, 8};
  localparam int HF[2] = '{16, 2};
  localparam int HW[2] = '{96, 3};
  localparam int HT[2] = '{800, 16};
  localparam int VA[2] = '{480, 6};
  localparam int VF[2] = '{10, 1};
  localparam int VW[2] = '{2, 2};
  localparam int VT[2] = '{525, 10};

  int   eh[2], ev[2];
  logic efs[2], epx[2];
  logic rst_q = 1'b0;
  logic chk_on = 1'b0;
  logic done = 1'b0;
  int   n_chk = 0, n_fail = 0;

  always @(posedge clk) begin
    rst_q <= rst_n;
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        eh[i] <= 0; ev[i] <= 0; efs[i] <= 1'b0; epx[i] <= 1'b0;
      end else begin
        efs[i] <= (eh[i] == HT[i] - 1) && (ev[i] == VT[i] - 1);
        epx[i] <= ~epx[i];
        eh[i]  <= (eh[i] == HT[i] - 1) ? 0 : eh[i] + 1;
        if (eh[i] == HT[i] - 1) ev[i] <= (ev[i] == VT[i] - 1) ? 0 : ev[i] + 1;
      end
    end
  end

  function automatic int exp_hs(int i, int h);
    return (h >= HA[i] + HF[i] && h < HA[i] + HF[i] + HW[i]) ? 0 : 1;
  endfunction

  function automatic int exp_vs(int i, int v);
    return (v >= VA[i] + VF[i] && v < VA[i] + VF[i] + VW[i]) ? 0 : 1;
  endfunction

  function automatic int exp_de(int i, int h, int v);
    return (h < HA[i] && v < VA[i]) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_inst(int i, int h, int v, int hs, int vs, int de, int px, int fs);
    if (!rst_q) begin
      chk("R8 reset h_count", h, 0);
      chk("R8 reset v_count", v, 0);
      chk("R8 reset hsync_n", hs, 1);
      chk("R8 reset vsync_n", vs, 1);
      chk("R8 reset pix_en", px, 0);
      chk("R8 reset frame_start", fs, 0);
    end
    chk("R1 h_count", h, eh[i]);
    chk("R2 v_count", v, ev[i]);
    chk("R3 frame_start", fs, int'(efs[i]));
    chk("R4 hsync_n", hs, exp_hs(i, eh[i]));
    chk("R5 vsync_n", vs, exp_vs(i, ev[i]));
    chk("R6 disp_en", de, exp_de(i, eh[i], ev[i]));
    chk("R7 pix_en", px, int'(epx[i]));
    if (i == 0) chk("R7 pix_en odd column", px, eh[i] % 2);
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check_inst(0, int'(bh), int'(bv), int'(bhs), int'(bvs), int'(bde), int'(bpx), int'(bfs));
      check_inst(1, int'(sh), int'(sv), int'(shs), int'(svs), int'(sde), int'(spx), int'(sfs));
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20517);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_on = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (24500) @(negedge clk);
    for (int k = 0; k < 25; k++) begin
      repeat ($urandom_range(2000, 1)) @(negedge clk);
      rst_n = 1'b0;
      repeat ($urandom_range(4, 1)) @(negedge clk);
      rst_n = 1'b1;
    end
    repeat (400) @(negedge clk);
    while (!(sh == 4'd15 && sv == 4'd9)) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (500) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule